// File: doc/BRIEF.md
# I2C Serial EEPROM Target Controller

This block is the bus-facing half of a 128-byte serial EEPROM. It watches an oversampled two-wire bus and pulls the data line low through an open-drain style output. It recognises bus start and stop events and answers only to its own device address, which is built from a fixed 4-bit code and three strap inputs. Write traffic is gathered into an 8-byte page buffer. Read traffic is served from a synchronous array port that has one cycle of read latency.

A write carries one word-address byte and then any number of data bytes. The data bytes land in the page buffer, and their offsets wrap inside the addressed page. A STOP then hands the whole page to a separate commit engine through a one-cycle request that carries the page index, a byte-valid mask and the buffered bytes. While that engine reports busy, the controller declines its own address. A master uses this to poll until the engine is done.

Reads start at the internal address pointer. This pointer always holds one more than the last byte touched. Reads keep streaming for as long as the master acknowledges each byte, and they wrap across the whole array.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A START (SDA falling while SCL is high) always begins reception of a new device-address byte, even in the middle of a byte. Any partially shifted bits are discarded.
- R2: The device-address byte is accepted only when bits 7..4 equal 1010 and bits 3..1 equal `strap_addr`. Otherwise no ACK is given and the bus is ignored until the next START. Bit 0 set to 1 means read and set to 0 means write.
- R3: Each accepted byte is acknowledged by asserting `sda_drive_low` for the ninth SCL clock. The output only starts to pull low after SCL has been seen low. After a STOP the output is released.
- R4: In a write, the byte after the device address is the word address, and its bits 6..0 load the pointer. Bit 7 is ignored.
- R5: Each write data byte goes to offset pointer[2:0] of the page pointer[6:3]. Only pointer[2:0] increments, so the ninth byte of a page write lands where the first one did.
- R6: A STOP that ends a write holding at least one complete data byte pulses `commit_req` for exactly one cycle. With the pulse come `commit_page` = pointer[6:3], bit i of `commit_mask` set for each written offset i, and byte i on `commit_data[8i+7:8i]`. A write with no data byte produces no pulse.
- R7: A current-address read returns the byte at the pointer, which is the address after the last byte accessed.
- R8: A random read is a word-address write, a repeated START, and then a read-mode device address. It returns the byte at the loaded address.
- R9: A read continues to successive addresses while the master ACKs, and it wraps from 127 to 0. After a master NACK the line is released and the transfer ends.
- R10: While `busy` is high the device address is not acknowledged.
- R11: A START that interrupts a write discards the buffered bytes, so a later STOP does not commit them.
- R12: After reset `sda_drive_low`, `commit_req` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL level from the bus |
| sda_in | input | 1 | Raw SDA level from the bus |
| strap_addr | input | 3 | Hard-wired device address bits |
| busy | input | 1 | Commit engine is writing the array |
| mem_rd_data | input | 8 | Array read data, valid one cycle after `mem_rd_en` |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | 7 | Array read address |
| commit_req | output | 1 | One-cycle page commit request |
| commit_page | output | 4 | Page index for the commit |
| commit_mask | output | 8 | Valid byte offsets in the page |
| commit_data | output | 64 | Page bytes, offset i at bits 8i+7:8i |

## Verification
A wrong pointer value shows at the ports on the very next read: the first byte shifted out on SDA comes from the wrong address. Counter wrap errors only show when a stream crosses the end of the page or the end of the array, so the tests start near those edges. A bit counter that is out of step moves the ACK slot, and the master sees a NACK within one byte. A page buffer or mask fault stays hidden until the STOP, and it then shows in the commit fields a few cycles later.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int          AW       = 7,
  parameter int          PW       = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_in,
  input  logic                    sda_in,
  input  logic [2:0]              strap_addr,
  input  logic                    busy,
  input  logic [7:0]              mem_rd_data,
  output logic                    sda_drive_low,
  output logic                    mem_rd_en,
  output logic [AW-1:0]           mem_rd_addr,
  output logic                    commit_req,
  output logic [AW-PW-1:0]        commit_page,
  output logic [(1<<PW)-1:0]      commit_mask,
  output logic [8*(1<<PW)-1:0]    commit_data
);
  localparam int NB = 1 << PW;

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADDR, ST_WR, ST_RD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p, scl_s, sda_s;
  logic       rise, fall, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_sy, sda_sy, scl_p, sda_p} <= '1;
    else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_p  <= scl_sy[1];
      sda_p  <= sda_sy[1];
    end

  assign scl_s   = scl_sy[1];
  assign sda_s   = sda_sy[1];
  assign rise    = scl_s & ~scl_p;
  assign fall    = ~scl_s & scl_p;
  assign start_c = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c  = scl_s & scl_p & ~sda_p & sda_s;

  st_t          st;
  logic [3:0]   bitcnt;
  logic [7:0]   shreg, tx, rd_hold;
  logic         rw, mack, rd_pend, sda_low;
  logic [AW-1:0] ptr;
  logic [NB-1:0] wmask;
  logic [7:0]   pbuf [NB];
  logic         dev_match;

  assign dev_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == strap_addr) && !busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_pend <= 1'b0;
      rd_hold <= '0;
    end else begin
      rd_pend <= mem_rd_en;
      if (rd_pend) rd_hold <= mem_rd_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_low <= 1'b0; ptr <= '0; wmask <= '0;
      mem_rd_en <= 1'b0; mem_rd_addr <= '0; commit_req <= 1'b0;
      for (int i = 0; i < NB; i++) pbuf[i] <= '0;
    end else begin
      mem_rd_en  <= 1'b0;
      commit_req <= 1'b0;
      if (start_c) begin
        st <= ST_DEV; bitcnt <= '0; sda_low <= 1'b0; wmask <= '0;
      end else if (stop_c) begin
        if (st == ST_WR && wmask != '0) commit_req <= 1'b1;
        st <= ST_IDLE; bitcnt <= '0; sda_low <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (rise && bitcnt != 4'd9) begin
          if (bitcnt < 4'd8) begin
            if (st != ST_RD) shreg <= {shreg[6:0], sda_s};
          end else if (st == ST_RD) mack <= ~sda_s;
          bitcnt <= bitcnt + 1'b1;
        end else if (fall && bitcnt == 4'd8) begin
          case (st)
            ST_DEV:
              if (dev_match) begin
                sda_low <= 1'b1;
                rw      <= shreg[0];
                if (shreg[0]) begin
                  mem_rd_en   <= 1'b1;
                  mem_rd_addr <= ptr;
                end
              end else begin
                st <= ST_IDLE; bitcnt <= '0;
              end
            ST_ADDR: begin
              sda_low <= 1'b1;
              ptr     <= shreg[AW-1:0];
            end
            ST_WR: begin
              sda_low              <= 1'b1;
              pbuf[ptr[PW-1:0]]    <= shreg;
              wmask[ptr[PW-1:0]]   <= 1'b1;
              ptr[PW-1:0]          <= ptr[PW-1:0] + 1'b1;
            end
            ST_RD: begin
              sda_low     <= 1'b0;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= ptr;
            end
            default: ;
          endcase
        end else if (fall && bitcnt == 4'd9) begin
          sda_low <= 1'b0;
          bitcnt  <= '0;
          case (st)
            ST_DEV:
              if (rw) begin
                st <= ST_RD;
                tx <= {rd_hold[6:0], 1'b0};
                sda_low <= ~rd_hold[7];
                ptr <= ptr + 1'b1;
              end else begin
                st <= ST_ADDR; wmask <= '0;
              end
            ST_ADDR: st <= ST_WR;
            ST_RD:
              if (mack) begin
                tx <= {rd_hold[6:0], 1'b0};
                sda_low <= ~rd_hold[7];
                ptr <= ptr + 1'b1;
              end else st <= ST_IDLE;
            default: ;
          endcase
        end else if (fall && st == ST_RD && bitcnt != 4'd0) begin
          sda_low <= ~tx[7];
          tx      <= {tx[6:0], 1'b0};
        end
      end
    end

  assign sda_drive_low = sda_low;
  assign commit_page   = ptr[AW-1:PW];
  assign commit_mask   = wmask;

  for (genvar g = 0; g < NB; g++) begin : g_cdata
    assign commit_data[8*g +: 8] = pbuf[g];
  end

  AST_DRIVE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !$past(scl_s)); // R3
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && $past(st) == ST_DEV) |-> !$past(busy)); // R10
  AST_COMMIT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> (commit_mask != '0)); // R6
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> !commit_req); // R6
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && $past(st) == ST_WR) |-> (ptr[AW-1:PW] == $past(ptr[AW-1:PW]))); // R5
  AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R9
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0]  strap_addr = 3'b101;
  logic        busy;
  logic [7:0]  mem_rd_data;
  logic        sda_drive_low, mem_rd_en, commit_req;
  logic [6:0]  mem_rd_addr;
  logic [3:0]  commit_page;
  logic [7:0]  commit_mask;
  logic [63:0] commit_data;
  logic        sda_bus;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]  model_mem [128];
  logic [7:0]  exp_mem [128];
  int          busy_cnt;
  int          ccount;
  logic [3:0]  cpage;
  logic [7:0]  cmask;
  logic [63:0] cdata;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_drive_low;
  assign busy    = busy_cnt != 0;

  i2c_eeprom_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .strap_addr(strap_addr), .busy(busy), .mem_rd_data(mem_rd_data),
    .sda_drive_low(sda_drive_low), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .commit_req(commit_req), .commit_page(commit_page), .commit_mask(commit_mask),
    .commit_data(commit_data)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) model_mem[i] <= init_val(i);
      busy_cnt <= 0; ccount <= 0; mem_rd_data <= '0;
      cpage <= '0; cmask <= '0; cdata <= '0;
    end else begin
      if (mem_rd_en) mem_rd_data <= model_mem[mem_rd_addr];
      if (commit_req) begin
        ccount <= ccount + 1;
        cpage <= commit_page; cmask <= commit_mask; cdata <= commit_data;
        for (int j = 0; j < 8; j++)
          if (commit_mask[j]) model_mem[{commit_page, 3'(j)}] <= commit_data[8*j +: 8];
        busy_cnt <= 2000;
      end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(4*Q);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_bus; tick(Q); scl_m = 1'b0;
    end
    tick(Q);
    sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic test_reset();
    chk("R12 sda released", sda_drive_low, 0);
    chk("R12 commit idle", commit_req, 0);
    chk("R12 read idle", mem_rd_en, 0);
  endtask

  task automatic test_bad_addr();
    logic a;
    i2c_start(); send_byte(8'hA0, a); chk("R2 strap mismatch nack", a, 0); i2c_stop();
    i2c_start(); send_byte(8'hBA, a); chk("R2 code mismatch nack", a, 0); i2c_stop();
  endtask

  task automatic test_byte_write();
    logic a0, a1, a2;
    int c0 = ccount;
    i2c_start(); send_byte(8'hAA, a0); send_byte(8'h93, a1); send_byte(8'h5C, a2); i2c_stop();
    chk("R3 ack dev/addr/data", {a0, a1, a2}, 3'b111);
    exp_mem[8'h13] = 8'h5C;
    chk("R6 one commit", ccount - c0, 1);
    chk("R4 R6 page index (addr bit7 ignored)", cpage, 2);
    chk("R6 mask", cmask, 8'h08);
    chk("R6 data lane 3", cdata[31:24], 8'h5C);
    chk("R3 released after stop", sda_drive_low, 0);
  endtask

  task automatic test_poll();
    logic a;
    int c0 = ccount;
    i2c_start(); send_byte(8'hAA, a); chk("R10 nack while busy", a, 0); i2c_stop();
    tick(2200);
    i2c_start(); send_byte(8'hAA, a); chk("R2 ack when idle", a, 1); i2c_stop();
    chk("R6 no commit without data", ccount - c0, 0);
  endtask

  task automatic test_page_wrap();
    logic a, ok;
    logic [63:0] ed;
    logic [7:0] d;
    ok = 1'b1;
    i2c_start(); send_byte(8'hAA, a); ok &= a; send_byte(8'h2E, a); ok &= a;
    for (int k = 0; k < 10; k++) begin
      send_byte(8'hC0 + 8'(k), a); ok &= a;
      exp_mem[8'h28 + 8'((6 + k) % 8)] = 8'hC0 + 8'(k);
    end
    i2c_stop();
    chk("R5 all bytes acked", ok, 1);
    for (int j = 0; j < 8; j++) ed[8*j +: 8] = exp_mem[8'h28 + j];
    chk("R5 page", cpage, 5);
    chk("R5 mask", cmask, 8'hFF);
    chk("R5 wrapped data", cdata, ed);
    tick(2200);
    i2c_start(); send_byte(8'hAB, a); recv_byte(d, 1'b0); i2c_stop();
    chk("R7 current read after wrap", d, exp_mem[8'h28]);
  endtask

  task automatic test_random_seq();
    logic a;
    logic [7:0] d0, d1, d2, d3;
    i2c_start(); send_byte(8'hAA, a); send_byte(8'h7E, a);
    i2c_start(); send_byte(8'hAB, a); chk("R8 read address ack", a, 1);
    recv_byte(d0, 1'b1); recv_byte(d1, 1'b1); recv_byte(d2, 1'b0);
    chk("R9 released after nack", sda_drive_low, 0);
    i2c_stop();
    chk("R8 random byte", d0, exp_mem[126]);
    chk("R9 next byte", d1, exp_mem[127]);
    chk("R9 wrap to 0", d2, exp_mem[0]);
    i2c_start(); send_byte(8'hAB, a); recv_byte(d3, 1'b0); i2c_stop();
    chk("R7 pointer after stream", d3, exp_mem[1]);
  endtask

  task automatic test_abort_write();
    logic a;
    logic [7:0] d;
    int c0 = ccount;
    i2c_start(); send_byte(8'hAA, a); send_byte(8'h40, a); send_byte(8'h11, a);
    i2c_start(); i2c_stop();
    chk("R11 no commit after restart", ccount - c0, 0);
    i2c_start(); send_byte(8'hAA, a); send_byte(8'h40, a);
    i2c_start(); send_byte(8'hAB, a); recv_byte(d, 1'b0); i2c_stop();
    chk("R11 array unchanged", d, exp_mem[8'h40]);
  endtask

  task automatic test_midbyte_start();
    logic a;
    logic [7:0] d;
    i2c_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    i2c_start(); send_byte(8'hAB, a);
    chk("R1 restart mid-byte ack", a, 1);
    recv_byte(d, 1'b0); i2c_stop();
    chk("R1 data after restart", d, exp_mem[8'h41]);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
    tick(5);
    test_reset();
    rst_n = 1'b1;
    tick(10);
    test_bad_addr();
    test_byte_write();
    test_poll();
    test_page_wrap();
    test_random_seq();
    test_abort_write();
    test_midbyte_start();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
    end
  end
endmodule